// File: doc/BRIEF.md
# Sync Frame Measurement Counter (Even/Odd Cycle)

This block counts the valid sync frames a time-triggered bus controller receives during the static segment of each communication cycle. It keeps two counters, one for even cycles and one for odd cycles. Each count tells the clock-correction logic how many entries of the matching 16-entry measurement table are valid. Entries at or beyond the count hold no meaning.

Each of the two receive channels delivers a valid-sync-frame strobe together with the frame ID. Each channel's frame passes through an optional mask/compare acceptance filter and an optional reject-ID filter. The two channels are then merged over a slot window. The window closes on a slot-end strobe, so a frame seen on both channels in one slot adds one, not two. The counters clear when the protocol state machine enters the startup states that rebuild the schedule. While the node is in its normal states, each counter also clears at its own point in the cycle. Both counts leave the block as 16-bit read-only status words.

Top module: `sync_meas_counter`

## Requirements
- R1: When `slot_end` is high and a qualified frame was seen in that slot window, the counter selected by `cycle_odd` increments by one in the next cycle. `cycle_odd` = 0 selects the even counter and 1 selects the odd counter. The other counter is left unchanged.
- R2: Channel A and channel B strobes that fall within one slot window (up to and including the `slot_end` cycle) add exactly one to the count.
- R3: With `acc_en` = 1, a frame qualifies only if `(id & acc_mask) == (acc_val & acc_mask)`. With `acc_en` = 0, every ID passes this filter.
- R4: With `rej_en` = 1, a frame whose ID equals `rej_id` is not counted. With `rej_en` = 0, this filter passes every ID.
- R5: Strobes that arrive while `in_static` = 0 are ignored.
- R6: A counter saturates at 15 and does not wrap.
- R7: Both counters read zero one cycle after `proto_state` changes to initialize-schedule (code 1) or coldstart-collision-resolution (code 2).
- R8: When `proto_state` is normal-active (code 3) or normal-passive (code 4), the even counter reads zero in the cycle after any cycle with `in_nit` = 1 and `cycle_odd` = 1. The odd counter is unaffected. In any other state, `in_nit` clears nothing.
- R9: When `proto_state` is code 3 or code 4, the odd counter reads zero in the cycle after a `cycle_end` pulse with `cycle_odd` = 0. The even counter is unaffected.
- R10: Both status words hold their count in bits 3:0 and read zero in bits 15:4. Both counts are zero after reset.
- R11: A count changes only in the cycle after a `slot_end` pulse or a clear. A slot that ends with no qualified frame adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cha_vld | input | 1 | Channel A valid sync frame strobe |
| cha_id | input | ID_W | Channel A frame ID |
| chb_vld | input | 1 | Channel B valid sync frame strobe |
| chb_id | input | ID_W | Channel B frame ID |
| slot_end | input | 1 | Closes the current slot window |
| cycle_odd | input | 1 | Parity of the current cycle (1 = odd) |
| in_static | input | 1 | Static segment in progress |
| in_nit | input | 1 | Network idle time in progress |
| cycle_end | input | 1 | Last clock of the current cycle |
| proto_state | input | 3 | Protocol state code (1, 2, 3, 4 as above; others neutral) |
| acc_en | input | 1 | Acceptance filter enable |
| acc_mask | input | ID_W | Acceptance filter mask |
| acc_val | input | ID_W | Acceptance filter compare value |
| rej_en | input | 1 | Rejection filter enable |
| rej_id | input | ID_W | ID to reject |
| even_word | output | WORD_W | Even cycle count status word |
| odd_word | output | WORD_W | Odd cycle count status word |

## Verification
The bench builds the block with its defaults: 11-bit IDs, a 4-bit count and 16-bit words. With these values a run of 20 slots is enough to push a counter past 15 and reach saturation. The 11-bit ID leaves room for masks that separate IDs differing only in one nibble, which exercises the acceptance compare on both its pass and fail sides. The reserved upper word bits are checked across the whole run, including while a counter sits at its limit.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam logic [2:0] PST_CONFIG    = 3'd0;
  localparam logic [2:0] PST_INIT_SCHD = 3'd1;
  localparam logic [2:0] PST_COLL_RES  = 3'd2;
  localparam logic [2:0] PST_NORM_ACT  = 3'd3;
  localparam logic [2:0] PST_NORM_PAS  = 3'd4;

  function automatic logic is_normal(input logic [2:0] st);
    return (st == PST_NORM_ACT) || (st == PST_NORM_PAS);
  endfunction

  function automatic logic is_restart(input logic [2:0] st);
    return (st == PST_INIT_SCHD) || (st == PST_COLL_RES);
  endfunction
endpackage

// File: rtl/smc_id_filter.sv
module smc_id_filter #(
  parameter int ID_W = 11
) (
  input  logic            vld_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            acc_en_i,
  input  logic [ID_W-1:0] acc_mask_i,
  input  logic [ID_W-1:0] acc_val_i,
  input  logic            rej_en_i,
  input  logic [ID_W-1:0] rej_id_i,
  output logic            pass_o
);
  logic acc_ok;
  logic rej_ok;

  always_comb begin
    acc_ok = !acc_en_i || ((id_i & acc_mask_i) == (acc_val_i & acc_mask_i));
    rej_ok = !rej_en_i || (id_i != rej_id_i);
    pass_o = vld_i && acc_ok && rej_ok;
  end
endmodule

// File: rtl/smc_slot_merge.sv
module smc_slot_merge #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pass_i,
  input  logic           in_static_i,
  input  logic           slot_end_i,
  output logic           inc_o
);
  logic pend_q;
  logic pend_n;
  logic hit;
  logic pend_en;

  always_comb begin
    hit     = in_static_i && (|pass_i);
    inc_o   = slot_end_i && (pend_q || hit);
    pend_en = slot_end_i || hit;
    pend_n  = slot_end_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_n;
  end
endmodule

// File: rtl/smc_sat_counter.sv
module smc_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != CMAX));
    cnt_n  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/smc_clear_ctrl.sv
module smc_clear_ctrl
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] proto_state_i,
  input  logic       cycle_odd_i,
  input  logic       in_nit_i,
  input  logic       cycle_end_i,
  output logic       clr_even_o,
  output logic       clr_odd_o
);
  logic [2:0] st_q;
  logic       entry;
  logic       norm;

  always_comb begin
    entry      = is_restart(proto_state_i) && (proto_state_i != st_q);
    norm       = is_normal(proto_state_i);
    clr_even_o = entry || (norm && cycle_odd_i && in_nit_i);
    clr_odd_o  = entry || (norm && !cycle_odd_i && cycle_end_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PST_CONFIG;
    else        st_q <= proto_state_i;
  end
endmodule

// File: rtl/sync_meas_counter.sv
module sync_meas_counter #(
  parameter int ID_W   = 11,
  parameter int CNT_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cha_vld,
  input  logic [ID_W-1:0]   cha_id,
  input  logic              chb_vld,
  input  logic [ID_W-1:0]   chb_id,
  input  logic              slot_end,
  input  logic              cycle_odd,
  input  logic              in_static,
  input  logic              in_nit,
  input  logic              cycle_end,
  input  logic [2:0]        proto_state,
  input  logic              acc_en,
  input  logic [ID_W-1:0]   acc_mask,
  input  logic [ID_W-1:0]   acc_val,
  input  logic              rej_en,
  input  logic [ID_W-1:0]   rej_id,
  output logic [WORD_W-1:0] even_word,
  output logic [WORD_W-1:0] odd_word
);
  localparam int NCH  = 2;
  localparam int PAD_W = WORD_W - CNT_W;

  logic [NCH-1:0]  ch_vld;
  logic [ID_W-1:0] ch_id [NCH];
  logic [NCH-1:0]  ch_pass;
  logic            slot_inc;
  logic            clr_even;
  logic            clr_odd;
  logic [CNT_W-1:0] cnt_even;
  logic [CNT_W-1:0] cnt_odd;

  always_comb begin
    ch_vld   = {chb_vld, cha_vld};
    ch_id[0] = cha_id;
    ch_id[1] = chb_id;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_filt
    smc_id_filter #(.ID_W(ID_W)) u_filt (
      .vld_i      (ch_vld[c]),
      .id_i       (ch_id[c]),
      .acc_en_i   (acc_en),
      .acc_mask_i (acc_mask),
      .acc_val_i  (acc_val),
      .rej_en_i   (rej_en),
      .rej_id_i   (rej_id),
      .pass_o     (ch_pass[c])
    );
  end

  smc_slot_merge #(.NCH(NCH)) u_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .pass_i      (ch_pass),
    .in_static_i (in_static),
    .slot_end_i  (slot_end),
    .inc_o       (slot_inc)
  );

  smc_clear_ctrl u_clr (
    .clk           (clk),
    .rst_n         (rst_n),
    .proto_state_i (proto_state),
    .cycle_odd_i   (cycle_odd),
    .in_nit_i      (in_nit),
    .cycle_end_i   (cycle_end),
    .clr_even_o    (clr_even),
    .clr_odd_o     (clr_odd)
  );

  smc_sat_counter #(.CNT_W(CNT_W)) u_cnt_even (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_even),
    .inc_i (slot_inc && !cycle_odd),
    .cnt_o (cnt_even)
  );

  smc_sat_counter #(.CNT_W(CNT_W)) u_cnt_odd (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_odd),
    .inc_i (slot_inc && cycle_odd),
    .cnt_o (cnt_odd)
  );

  assign even_word = {{PAD_W{1'b0}}, cnt_even};
  assign odd_word  = {{PAD_W{1'b0}}, cnt_odd};
endmodule

// File: rtl/smc_checker.sv
module smc_checker
  import smc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_end,
  input logic              cycle_odd,
  input logic              in_nit,
  input logic              cycle_end,
  input logic [2:0]        proto_state,
  input logic [WORD_W-1:0] even_word,
  input logic [WORD_W-1:0] odd_word
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (even_word[WORD_W-1:CNT_W] == '0) && (odd_word[WORD_W-1:CNT_W] == '0));

  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_restart(proto_state) && proto_state != $past(proto_state))
    |=> (even_word == '0 && odd_word == '0));

  assert_nit_clear_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_normal(proto_state) && cycle_odd && in_nit) |=> (even_word == '0));

  assert_cycend_clear_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_normal(proto_state) && !cycle_odd && cycle_end) |=> (odd_word == '0));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (even_word[CNT_W-1:0] == CMAX && slot_end) |=>
      (even_word[CNT_W-1:0] == CMAX || even_word[CNT_W-1:0] == '0));

  assert_even_grows_on_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> (even_word[CNT_W-1:0] <= $past(even_word[CNT_W-1:0])));

  assert_odd_grows_on_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> (odd_word[CNT_W-1:0] <= $past(odd_word[CNT_W-1:0])));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, even_word[CNT_W-1:0]} <= {1'b0, $past(even_word[CNT_W-1:0])} + 1'b1)
          && ({1'b0, odd_word[CNT_W-1:0]} <= {1'b0, $past(odd_word[CNT_W-1:0])} + 1'b1));
endmodule

bind sync_meas_counter smc_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_end    (slot_end),
  .cycle_odd   (cycle_odd),
  .in_nit      (in_nit),
  .cycle_end   (cycle_end),
  .proto_state (proto_state),
  .even_word   (even_word),
  .odd_word    (odd_word)
);

// File: tb/sim_sync_meas_counter.sv
module sim_sync_meas_counter;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 11;

  logic clk;
  logic rst_n;
  logic cha_vld, chb_vld, slot_end, cycle_odd, in_static, in_nit, cycle_end;
  logic [ID_W-1:0] cha_id, chb_id, acc_mask, acc_val, rej_id;
  logic acc_en, rej_en;
  logic [2:0] proto_state;
  logic [15:0] even_word, odd_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sync_meas_counter u0 (
    .clk(clk), .rst_n(rst_n),
    .cha_vld(cha_vld), .cha_id(cha_id), .chb_vld(chb_vld), .chb_id(chb_id),
    .slot_end(slot_end), .cycle_odd(cycle_odd), .in_static(in_static),
    .in_nit(in_nit), .cycle_end(cycle_end), .proto_state(proto_state),
    .acc_en(acc_en), .acc_mask(acc_mask), .acc_val(acc_val),
    .rej_en(rej_en), .rej_id(rej_id),
    .even_word(even_word), .odd_word(odd_word)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slot(input bit av, input int aid, input bit bv, input int bid);
    @(negedge clk);
    cha_vld = av; cha_id = ID_W'(aid);
    chb_vld = bv; chb_id = ID_W'(bid);
    @(negedge clk);
    cha_vld = 0; chb_vld = 0; slot_end = 1;
    @(negedge clk);
    slot_end = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset even", int'(even_word), 0);
    chk("R10 reset odd", int'(odd_word), 0);
  endtask

  task automatic t_basic();
    cycle_odd = 0; in_static = 1;
    slot(1, 'h010, 0, 0);
    chk("R1 even +1", int'(even_word), 1);
    chk("R1 odd untouched", int'(odd_word), 0);
    slot(0, 0, 1, 'h011);
    chk("R1 chan B even +1", int'(even_word), 2);
    cycle_odd = 1;
    slot(1, 'h012, 0, 0);
    chk("R1 odd +1", int'(odd_word), 1);
    chk("R1 even kept", int'(even_word), 2);
    cycle_odd = 0;
  endtask

  task automatic t_dual();
    int e0 = int'(even_word);
    slot(1, 'h020, 1, 'h020);
    chk("R2 both channels once", int'(even_word), e0 + 1);
    // strobe on A, then B on slot_end cycle: still one
    @(negedge clk); cha_vld = 1; cha_id = 'h021;
    @(negedge clk); cha_vld = 0; chb_vld = 1; chb_id = 'h021; slot_end = 1;
    @(negedge clk); chb_vld = 0; slot_end = 0;
    chk("R2 split strobes once", int'(even_word), e0 + 2);
    slot(0, 0, 0, 0);
    chk("R11 empty slot", int'(even_word), e0 + 2);
  endtask

  task automatic t_acc();
    int e0 = int'(even_word);
    acc_en = 1; acc_mask = 'h0F0; acc_val = 'h050;
    slot(1, 'h153, 0, 0);
    chk("R3 accept match", int'(even_word), e0 + 1);
    slot(1, 'h163, 0, 0);
    chk("R3 reject mismatch", int'(even_word), e0 + 1);
    acc_en = 0;
    slot(1, 'h163, 0, 0);
    chk("R3 disabled passes", int'(even_word), e0 + 2);
  endtask

  task automatic t_rej();
    int e0 = int'(even_word);
    rej_en = 1; rej_id = 'h007;
    slot(1, 'h007, 0, 0);
    chk("R4 reject id", int'(even_word), e0);
    slot(1, 'h008, 0, 0);
    chk("R4 other id", int'(even_word), e0 + 1);
    rej_en = 0;
    slot(1, 'h007, 0, 0);
    chk("R4 disabled", int'(even_word), e0 + 2);
  endtask

  task automatic t_static();
    int e0 = int'(even_word);
    in_static = 0;
    slot(1, 'h030, 1, 'h030);
    chk("R5 outside static", int'(even_word), e0);
    in_static = 1;
  endtask

  task automatic nit_pulse();
    @(negedge clk); in_static = 0; cycle_odd = 1; in_nit = 1;
    @(negedge clk); in_nit = 0; cycle_odd = 0; in_static = 1;
  endtask

  task automatic t_nit();
    int e0 = int'(even_word);
    int o0 = int'(odd_word);
    proto_state = 3'd0;
    @(negedge clk);
    nit_pulse();
    chk("R8 no clear in config", int'(even_word), e0);
    proto_state = 3'd4;
    nit_pulse();
    chk("R8 even cleared", int'(even_word), 0);
    chk("R8 odd kept", int'(odd_word), o0);
    proto_state = 3'd3;
  endtask

  task automatic t_cycend();
    int o0;
    slot(1, 'h040, 0, 0);
    cycle_odd = 1;
    slot(1, 'h041, 0, 0);
    cycle_odd = 0;
    o0 = int'(odd_word);
    @(negedge clk); cycle_odd = 1; cycle_end = 1;
    @(negedge clk); cycle_end = 0; cycle_odd = 0;
    chk("R9 no clear at odd end", int'(odd_word), o0);
    @(negedge clk); cycle_end = 1;
    @(negedge clk); cycle_end = 0;
    chk("R9 odd cleared", int'(odd_word), 0);
    chk("R9 even kept", int'(even_word), 1);
  endtask

  task automatic t_entry();
    cycle_odd = 1; slot(1, 'h050, 0, 0); cycle_odd = 0;
    slot(1, 'h051, 0, 0);
    @(negedge clk); proto_state = 3'd1;
    @(negedge clk);
    chk("R7 init sched even", int'(even_word), 0);
    chk("R7 init sched odd", int'(odd_word), 0);
    proto_state = 3'd3;
    slot(1, 'h052, 0, 0);
    cycle_odd = 1; slot(1, 'h053, 0, 0); cycle_odd = 0;
    @(negedge clk); proto_state = 3'd2;
    @(negedge clk);
    chk("R7 coll res even", int'(even_word), 0);
    chk("R7 coll res odd", int'(odd_word), 0);
    proto_state = 3'd3;
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) slot(1, 'h060 + i, 0, 0);
    chk("R6 saturate", int'(even_word), 15);
    chk("R10 upper bits", int'(even_word[15:4]), 0);
  endtask

  initial begin
    rst_n = 0;
    cha_vld = 0; chb_vld = 0; cha_id = '0; chb_id = '0;
    slot_end = 0; cycle_odd = 0; in_static = 0; in_nit = 0; cycle_end = 0;
    proto_state = 3'd3;
    acc_en = 0; acc_mask = '0; acc_val = '0; rej_en = 0; rej_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dual();
    t_acc();
    t_rej();
    t_static();
    t_nit();
    t_cycend();
    t_entry();
    t_sat();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule